// File: doc/BRIEF.md
# Split-Transaction Request Tracking Table

This block keeps a record of every transaction still open on a snooping bus where requests and responses travel in separate phases. When a requester presents a command with its byte address, the table decides in the same cycle whether to take it. If it takes the request, the table hands back a small tag that names the transaction until its response comes back. If it refuses the request, it raises a refusal line and the requester must try again later. The block never stalls a request.

There are two reasons to refuse a request. The first is that every slot is in use. The second is that the new address falls in a cache line that already has an open transaction, since only one transaction per line may be in flight. The order in which the table grants requests is the global order of memory accesses. Responses can close transactions in any order. A response carries a tag; it frees that tag's slot and reads back the line and command recorded for it. A response that names a tag with no open transaction is flagged as an error and ignored.

When a response and a request arrive in the same cycle, the retirement is handled first. The freed slot, and the line it held, are then already available to the request in that cycle.

Top module: `xact_tag_table`

## Requirements
- R1: After reset all eight slots are free, no output is raised while idle, and the first request is granted tag 0.
- R2: A request that finds a free slot and no line conflict gets req_grant=1 and req_nack=0 in the same cycle. req_tag is the lowest-numbered free tag.
- R3: At most DEPTH (8) transactions are open at once. A request made while all slots are held, with no retirement in that cycle, gets req_nack=1 and req_grant=0.
- R4: A request is refused with req_nack=1 when address bits [31:7] equal the line of any open slot. Addresses that differ only in bits [6:0] are treated as the same line.
- R5: A refused request allocates nothing. The next granted request receives the same tag it would have received if the refused request had never been made.
- R6: A response with an allocated tag frees that slot, in any order relative to grant order. Later requests can then be granted that tag again, lowest free tag first.
- R7: A response whose tag is not allocated raises rsp_err in the same cycle and leaves every slot unchanged.
- R8: When a response and a request come in the same cycle, the retirement happens first. A full table whose slot is being retired grants that tag, and a request to the line being retired is not refused for conflict.
- R9: On a valid retirement (rsp_valid=1, rsp_err=0), rsp_line and rsp_cmd show the line address bits [31:7] and the command stored when that tag was granted.
- R10: With req_valid=0, req_grant and req_nack stay 0. With rsp_valid=0, rsp_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_cmd | input | CMD_W (4) | Command type of the request |
| req_addr | input | ADDR_W (32) | Byte address of the request |
| req_grant | output | 1 | Request taken this cycle |
| req_nack | output | 1 | Request refused; the requester must retry |
| req_tag | output | TAG_W (3) | Tag given to the taken request |
| rsp_valid | input | 1 | A response is retiring a tag this cycle |
| rsp_tag | input | TAG_W (3) | Tag being retired |
| rsp_err | output | 1 | Retired tag was not allocated |
| rsp_line | output | ADDR_W-LINE_OFS (25) | Line address recorded for the retired tag |
| rsp_cmd | output | CMD_W (4) | Command recorded for the retired tag |

## Verification
The bound checker keeps its own shadow of which tags are open and how many, built only from port activity. Against that shadow it checks on every cycle that the request outcome is exclusive, that the error flag agrees with the open state of each tag, that a full table refuses, and that a granted tag was actually free. Line conflict detection, the lowest-tag choice, and the recorded line and command are checked only by the bench scenarios. The bench compares every cycle against an arithmetic model, through directed fill, drain and collision cases and a long pseudo-random run over a few lines that collide often.

// File: rtl/xtt_pkg.sv
package xtt_pkg;

   typedef enum logic [1:0] {
      OUTC_IDLE = 2'd0,
      OUTC_TAKE = 2'd1,
      OUTC_FULL = 2'd2,
      OUTC_DUP  = 2'd3
   } req_outcome_e;

   function automatic logic outcome_nack(input req_outcome_e o);
      return (o == OUTC_FULL) || (o == OUTC_DUP);
   endfunction

endpackage

// File: rtl/xtt_slot.sv
module xtt_slot #(
   parameter int LINE_W = 25,
   parameter int CMD_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [LINE_W-1:0] probe_i,
   output logic              busy_o,
   output logic              match_o,
   output logic [LINE_W-1:0] line_o,
   output logic [CMD_W-1:0]  cmd_o
);

   logic              busy_q;
   logic [LINE_W-1:0] line_q;
   logic [CMD_W-1:0]  cmd_q;

   // a new occupant written in the same cycle as a retirement wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         line_q <= '0;
         cmd_q  <= '0;
      end else if (set_i) begin
         busy_q <= 1'b1;
         line_q <= line_i;
         cmd_q  <= cmd_i;
      end else if (clr_i) begin
         busy_q <= 1'b0;
      end
   end

   assign busy_o  = busy_q;
   assign match_o = busy_q && (line_q == probe_i);
   assign line_o  = line_q;
   assign cmd_o   = cmd_q;

endmodule

// File: rtl/xtt_lowfree.sv
module xtt_lowfree #(
   parameter int N          = 8,
   parameter int TAG_W      = 3,
   parameter bit USE_ONEHOT = 1'b0
) (
   input  logic [N-1:0]     free_i,
   output logic             any_o,
   output logic [TAG_W-1:0] idx_o
);

   assign any_o = |free_i;

   generate
      if (USE_ONEHOT) begin : g_onehot
         logic [N-1:0] lowest;
         assign lowest = free_i & (~free_i + N'(1));
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < N; i++) begin
               if (lowest[i]) idx_o = idx_o | TAG_W'(i);
            end
         end
      end else begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (free_i[i]) idx_o = TAG_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/xact_tag_table.sv
module xact_tag_table
   import xtt_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_OFS   = 7,
   parameter int DEPTH      = 8,
   parameter int CMD_W      = 4,
   parameter bit PICK_ONEHOT = 1'b0,
   localparam int TAG_W     = $clog2(DEPTH),
   localparam int LINE_W    = ADDR_W - LINE_OFS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_grant,
   output logic              req_nack,
   output logic [TAG_W-1:0]  req_tag,
   input  logic              rsp_valid,
   input  logic [TAG_W-1:0]  rsp_tag,
   output logic              rsp_err,
   output logic [LINE_W-1:0] rsp_line,
   output logic [CMD_W-1:0]  rsp_cmd
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (LINE_OFS < 0 || LINE_OFS >= ADDR_W) begin : g_bad_ofs
         $error("LINE_OFS must lie inside the address");
      end
      if (CMD_W < 1) begin : g_bad_cmd
         $error("CMD_W must be positive");
      end
   endgenerate

   logic [LINE_W-1:0] probe_line;
   logic [DEPTH-1:0]  busy, match, set_v, clr_v, free_v, hit_v;
   logic [LINE_W-1:0] slot_line [DEPTH];
   logic [CMD_W-1:0]  slot_cmd  [DEPTH];
   logic              retire_ok;
   logic              pick_any;
   logic [TAG_W-1:0]  pick_idx;
   req_outcome_e      outcome;

   assign probe_line = req_addr[ADDR_W-1:LINE_OFS];

   // retirement is resolved before the request is judged
   assign retire_ok = rsp_valid && busy[rsp_tag];
   assign rsp_err   = rsp_valid && !busy[rsp_tag];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         assign clr_v[g]  = retire_ok && (rsp_tag == TAG_W'(g));
         assign free_v[g] = !busy[g] || clr_v[g];
         assign hit_v[g]  = match[g] && !clr_v[g];
         assign set_v[g]  = req_grant && (pick_idx == TAG_W'(g));

         xtt_slot #(
            .LINE_W (LINE_W),
            .CMD_W  (CMD_W)
         ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_v[g]),
            .clr_i   (clr_v[g]),
            .line_i  (probe_line),
            .cmd_i   (req_cmd),
            .probe_i (probe_line),
            .busy_o  (busy[g]),
            .match_o (match[g]),
            .line_o  (slot_line[g]),
            .cmd_o   (slot_cmd[g])
         );
      end
   endgenerate

   xtt_lowfree #(
      .N          (DEPTH),
      .TAG_W      (TAG_W),
      .USE_ONEHOT (PICK_ONEHOT)
   ) u_pick (
      .free_i (free_v),
      .any_o  (pick_any),
      .idx_o  (pick_idx)
   );

   always_comb begin
      if (!req_valid)     outcome = OUTC_IDLE;
      else if (|hit_v)    outcome = OUTC_DUP;
      else if (!pick_any) outcome = OUTC_FULL;
      else                outcome = OUTC_TAKE;
   end

   assign req_grant = (outcome == OUTC_TAKE);
   assign req_nack  = outcome_nack(outcome);
   assign req_tag   = req_grant ? pick_idx : '0;

   always_comb begin
      rsp_line = '0;
      rsp_cmd  = '0;
      if (retire_ok) begin
         rsp_line = slot_line[rsp_tag];
         rsp_cmd  = slot_cmd[rsp_tag];
      end
   end

endmodule

// File: rtl/xtt_checker.sv
module xtt_checker #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_grant,
   input logic             req_nack,
   input logic [TAG_W-1:0] req_tag,
   input logic             rsp_valid,
   input logic [TAG_W-1:0] rsp_tag,
   input logic             rsp_err
);

   logic [DEPTH-1:0] shadow;
   logic [TAG_W:0]   open_cnt;
   logic             good_ret;

   assign good_ret = rsp_valid && !rsp_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow   <= '0;
         open_cnt <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (req_grant && req_tag == TAG_W'(i))     shadow[i] <= 1'b1;
            else if (good_ret && rsp_tag == TAG_W'(i)) shadow[i] <= 1'b0;
         end
         open_cnt <= open_cnt + (TAG_W+1)'(req_grant) - (TAG_W+1)'(good_ret);
      end
   end

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!req_grant && !req_nack && (rsp_valid || !rsp_err)));

   // R2
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_grant != req_nack));

   // R7
   err_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_err == !shadow[rsp_tag]));

   // R3
   full_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && open_cnt == (TAG_W+1)'(DEPTH) && !good_ret) |-> req_nack);

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_cnt <= (TAG_W+1)'(DEPTH));

   // R6
   fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |-> (!shadow[req_tag] || (good_ret && rsp_tag == req_tag)));

   // R6
   granted_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |=> !(rsp_valid && rsp_tag == $past(req_tag) && rsp_err));

endmodule

bind xact_tag_table xtt_checker #(
   .DEPTH (DEPTH),
   .TAG_W (TAG_W)
) u_xtt_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_grant (req_grant),
   .req_nack  (req_nack),
   .req_tag   (req_tag),
   .rsp_valid (rsp_valid),
   .rsp_tag   (rsp_tag),
   .rsp_err   (rsp_err)
);

// File: tb/test_xact_tag_table.sv
module test_xact_tag_table;

   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_cmd = '0;
   logic [31:0] req_addr = '0;
   logic        req_grant, req_nack, rsp_err;
   logic [2:0]  req_tag;
   logic        rsp_valid = 1'b0;
   logic [2:0]  rsp_tag = '0;
   logic [24:0] rsp_line;
   logic [3:0]  rsp_cmd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        ev [8];
   logic [24:0] el [8];
   logic [3:0]  ec [8];

   always #(PERIOD/2) clk = ~clk;

   xact_tag_table i_xact_tag_table (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
      .req_grant(req_grant), .req_nack(req_nack), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_err(rsp_err),
      .rsp_line(rsp_line), .rsp_cmd(rsp_cmd)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // one cycle: drive at the falling edge, compare, commit at the rising edge
   task automatic step(input logic rv, input logic [31:0] a, input logic [3:0] c,
                       input logic sv, input logic [2:0] st, input string rq);
      logic ret_ok, e_err, conf, anyfree, e_grant, e_nack;
      logic [2:0] pick;
      req_valid = rv; req_addr = a; req_cmd = c;
      rsp_valid = sv; rsp_tag = st;
      #1;
      ret_ok = sv && ev[st];
      e_err  = sv && !ev[st];
      conf = 1'b0; anyfree = 1'b0; pick = '0;
      for (int i = 7; i >= 0; i--) begin
         logic fr;
         fr = !ev[i] || (ret_ok && st == 3'(i));
         if (fr) begin anyfree = 1'b1; pick = 3'(i); end
         if (ev[i] && !(ret_ok && st == 3'(i)) && el[i] == a[31:7]) conf = 1'b1;
      end
      e_grant = rv && anyfree && !conf;
      e_nack  = rv && !e_grant;
      chk(rq, "grant", int'(req_grant), int'(e_grant));
      chk(rq, "nack", int'(req_nack), int'(e_nack));
      chk(rq, "err", int'(rsp_err), int'(e_err));
      if (e_grant) chk(rq, "tag", int'(req_tag), int'(pick));
      if (ret_ok) begin
         chk(rq, "rsp_line", int'(rsp_line), int'(el[st]));
         chk(rq, "rsp_cmd", int'(rsp_cmd), int'(ec[st]));
      end
      @(posedge clk);
      if (ret_ok) ev[st] = 1'b0;
      if (e_grant) begin ev[pick] = 1'b1; el[pick] = a[31:7]; ec[pick] = c; end
      @(negedge clk);
      req_valid = 1'b0; rsp_valid = 1'b0;
   endtask

   function automatic logic [31:0] mk(input int line, input int low);
      return 32'h4000_0000 | (32'(line) << 7) | 32'(low & 127);
   endfunction

   initial begin
      for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; el[i] = '0; ec[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, idle
      step(0, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 0, 0, "R10");
      // R1 first grant is tag 0; R2 fill distinct lines
      step(1, mk(10, 3), 4'h1, 0, 0, "R1");
      for (int i = 1; i < 8; i++) step(1, mk(10 + i, i * 9), 4'(i + 2), 0, 0, "R2");
      // R3 full table refuses
      step(1, mk(40, 0), 4'h5, 0, 0, "R3");
      step(1, mk(41, 0), 4'h6, 0, 0, "R3");
      // R6 out-of-order retirement, R9 readback
      step(0, 0, 0, 1, 3'd5, "R9");
      step(0, 0, 0, 1, 3'd2, "R6");
      step(0, 0, 0, 1, 3'd6, "R9");
      // R4 same line, other offset bits
      step(1, mk(10, 127), 4'h7, 0, 0, "R4");
      step(1, mk(13, 0), 4'h7, 0, 0, "R4");
      // R5 refusal changes nothing; R6 lowest freed tag reused
      step(1, mk(50, 1), 4'h8, 0, 0, "R5");
      // R7 unallocated tag
      step(0, 0, 0, 1, 3'd5, "R7");
      step(1, mk(51, 1), 4'h9, 0, 0, "R7");
      step(1, mk(52, 1), 4'hA, 0, 0, "R6");
      // R8 full table, same-cycle retire of tag 3
      step(1, mk(53, 0), 4'hB, 1, 3'd3, "R8");
      // R8 request to the line being retired (tag 1 holds line 11)
      step(1, mk(11, 64), 4'hC, 1, 3'd1, "R8");
      // R10 error with no request
      step(0, 0, 0, 0, 3'd0, "R10");
      // drain everything
      for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 3'(i), "R6");
      step(0, 0, 0, 1, 3'd4, "R7");
      // sweep over a handful of lines that collide often
      begin
         bit [31:0] s = 32'h1234_5678;
         for (int n = 0; n < 3000; n++) begin
            logic rv, sv;
            s = s * 32'd1103515245 + 32'd12345;
            rv = s[20] | s[21];
            sv = s[22] & (s[23] | s[24]);
            step(rv, mk(int'(s[27:25]) + int'(s[28]) * 8, int'(s[15:9])),
                 s[19:16], sv, s[31:29], "R8");
         end
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=timeout expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule